// File: doc/BRIEF.md
# Framed Word Serializer with Training Pattern

This block turns a stream of 10-bit parallel words into a serial bit stream. It sends each word as a 12-bit frame. A high start bit comes first and a low stop bit comes last, and this fixed edge at every frame boundary lets a receiver recover the clock from the data. All logic runs on a single bit clock at twelve times the word rate. The word clock arrives as a signal that the bit clock samples. A configuration input chooses whether a word is latched on the rising or the falling transition of that word clock. The latched word goes out in the frame that follows.

A receiver can ask for training through either of two sync request inputs. A request counts once a request has been seen at five consecutive rising word-clock transitions. From then on the block ignores the parallel words and sends a frame of six ones followed by six zeros in every word period. It goes back to data once both requests are seen low. The serial pin is tri-stated until the clock source reports lock, and it drives only while the output enable is high.

Top module: `embClkSerializer`

## Requirements
- R1: Each data frame carries the start value 1 at position 0, payload bits 0 to 9 least significant first at positions 1 to 10, and the stop value 0 at position 11. Position k is on `serData` while the frame counter holds k.
- R2: A 4-bit position counter steps 0,1,...,11,0 on every bit clock. A new frame is loaded when the counter wraps, so frames follow each other with no gap.
- R3: With `edgeSel`=1 the word present at a sampled rising transition of `wordClk` is latched. With `edgeSel`=0 the word at a sampled falling transition is latched. The word latched during one frame is sent in the next frame.
- R4: After a sync request has been seen at 5 consecutive rising word-clock transitions, every frame loaded is 1 at positions 0 to 5 and 0 at positions 6 to 11, and the parallel data is ignored.
- R5: A request held for fewer than 5 rising transitions does not change the frames, which keep carrying data.
- R6: Either request input alone, or both together, trigger the training frame.
- R7: Once both requests are seen low at a rising transition, the next frame loaded carries data again.
- R8: `serDrive` is 1 only when `pllLock` and `outEn` are both 1. `serOut` follows `serData` while `serDrive` is 1 and is high-impedance otherwise. The frame sequence on `serData` goes on regardless.
- R9: During and after reset `serData` is 0, and the first frame after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the word rate |
| rstN | input | 1 | Asynchronous active-low reset |
| wordClk | input | 1 | Word clock, sampled by the bit clock |
| edgeSel | input | 1 | 1 latches on the rising word transition, 0 on the falling one |
| dataIn | input | 10 | Parallel payload word |
| syncReqA | input | 1 | First training request |
| syncReqB | input | 1 | Second training request |
| pllLock | input | 1 | Clock source locked |
| outEn | input | 1 | Output enable |
| serData | output | 1 | Serial bit before the tri-state stage |
| serDrive | output | 1 | 1 while the serial pin is driven |
| serOut | output | 1 | Tri-stated serial output |

## Verification
The properties assume that the word clock is phase-locked to the frame counter. That means one high half and one low half per 12 bit clocks, with the rising transition sampled when the counter is at 0. They also assume that data and request inputs change only between bit-clock edges. The stimulus meets this by deriving the word clock, payload and requests from its own position count and driving them on falling bit-clock edges. The rising and falling word transitions see different payloads, so the latch edge shows up in the frame. Request runs of four, seven and eight words probe the five-transition threshold and the return to data.

// File: rtl/serPkg.sv
package serPkg;
  typedef struct packed {
    logic loadFrame;
    logic sendSync;
    logic captureWord;
    logic driveOut;
  } serStrobes_t;
endpackage

// File: rtl/wordCtrl.sv
module wordCtrl
  import serPkg::*;
#(
  parameter int FRAME_W    = 12,
  parameter int SYNC_WORDS = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wordClk,
  input  logic                       edgeSel,
  input  logic                       syncReqA,
  input  logic                       syncReqB,
  input  logic                       pllLock,
  input  logic                       outEn,
  output serStrobes_t                strobes,
  output logic [$clog2(FRAME_W)-1:0] bitPos
);
  localparam int POS_W = $clog2(FRAME_W);
  localparam int CNT_W = $clog2(SYNC_WORDS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] SYNC_MAX = CNT_W'(SYNC_WORDS);

  logic             wordClkQ;
  logic             wordRise;
  logic             wordFall;
  logic [CNT_W-1:0] syncCnt;
  logic             syncWanted;

  assign wordRise   = wordClk & ~wordClkQ;
  assign wordFall   = ~wordClk & wordClkQ;
  assign syncWanted = syncReqA | syncReqB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordClkQ <= 1'b0;
    else       wordClkQ <= wordClk;
  end

  // position within the frame, wraps after the stop bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bitPos <= '0;
    else if (bitPos == LAST_POS) bitPos <= '0;
    else                       bitPos <= bitPos + POS_W'(1);
  end

  // request persistence counted in word periods, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncCnt <= '0;
    else if (wordRise) begin
      if (!syncWanted)           syncCnt <= '0;
      else if (syncCnt != SYNC_MAX) syncCnt <= syncCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.loadFrame   = (bitPos == LAST_POS);
    strobes.sendSync    = (syncCnt == SYNC_MAX);
    strobes.captureWord = edgeSel ? wordRise : wordFall;
    strobes.driveOut    = pllLock & outEn;
  end
endmodule

// File: rtl/frameDatapath.sv
module frameDatapath
  import serPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  serStrobes_t       strobes,
  output logic              serData
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int HIGH_W  = FRAME_W / 2;

  logic [DATA_W-1:0]  capWord;
  logic [FRAME_W-1:0] dataFrame;
  logic [FRAME_W-1:0] syncFrame;
  logic [FRAME_W-1:0] nextFrame;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    capWord <= '0;
    else if (strobes.captureWord) capWord <= dataIn;
  end

  // position 0 leaves first: stop at the top, start at the bottom
  assign dataFrame = {1'b0, capWord, 1'b1};

  for (genvar i = 0; i < FRAME_W; i++) begin : g_train
    assign syncFrame[i] = (i < HIGH_W) ? 1'b1 : 1'b0;
  end

  assign nextFrame = strobes.sendSync ? syncFrame : dataFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shiftReg <= '0;
    else if (strobes.loadFrame) shiftReg <= nextFrame;
    else                        shiftReg <= {1'b0, shiftReg[FRAME_W-1:1]};
  end

  assign serData = shiftReg[0];
endmodule

// File: rtl/embClkSerializer.sv
module embClkSerializer
  import serPkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int SYNC_WORDS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordClk,
  input  logic              edgeSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncReqA,
  input  logic              syncReqB,
  input  logic              pllLock,
  input  logic              outEn,
  output logic              serData,
  output logic              serDrive,
  output logic              serOut
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int POS_W   = $clog2(FRAME_W);

  serStrobes_t      strobes;
  logic [POS_W-1:0] bitPos;

  wordCtrl #(.FRAME_W(FRAME_W), .SYNC_WORDS(SYNC_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .edgeSel(edgeSel),
    .syncReqA(syncReqA), .syncReqB(syncReqB), .pllLock(pllLock),
    .outEn(outEn), .strobes(strobes), .bitPos(bitPos)
  );

  frameDatapath #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobes(strobes),
    .serData(serData)
  );

  assign serDrive = strobes.driveOut;
  assign serOut   = serDrive ? serData : 1'bz;
endmodule

// File: rtl/embClkSerializerChk.sv
module embClkSerializerChk #(
  parameter int FRAME_W = 12
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pllLock,
  input logic                       outEn,
  input logic                       serData,
  input logic                       serDrive,
  input logic [$clog2(FRAME_W)-1:0] bitPos,
  input logic                       loadFrame
);
  localparam int POS_W = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  // R2
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitPos == LAST_POS |=> bitPos == '0);

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitPos != LAST_POS |=> bitPos == $past(bitPos) + POS_W'(1));

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadFrame |=> serData);

  // R1
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitPos == LAST_POS |-> !serData);

  // R8
  no_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pllLock |-> !serDrive);

  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    serDrive |-> outEn);
endmodule

bind embClkSerializer embClkSerializerChk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rstN(rstN), .pllLock(pllLock), .outEn(outEn),
  .serData(serData), .serDrive(serDrive), .bitPos(bitPos),
  .loadFrame(strobes.loadFrame)
);

// File: tb/embClkSerializer_test.sv
module embClkSerializer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wordClk = 1'b0;
  logic       edgeSel = 1'b1;
  logic [9:0] dataIn = '0;
  logic       syncReqA = 1'b0;
  logic       syncReqB = 1'b0;
  logic       pllLock = 1'b0;
  logic       outEn = 1'b0;
  logic       serData, serDrive, serOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int          syncCnt = 0;
  logic [11:0] nextExp = '0;
  string       nextTag = "R9 first frame";
  bit          prevSync = 0;

  always #5 clk = ~clk;

  embClkSerializer uut (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .edgeSel(edgeSel),
    .dataIn(dataIn), .syncReqA(syncReqA), .syncReqB(syncReqB),
    .pllLock(pllLock), .outEn(outEn), .serData(serData),
    .serDrive(serDrive), .serOut(serOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one word period; the current position equals p after each falling edge
  task automatic doWord(input logic [9:0] a, input logic [9:0] b, input bit es,
                        input bit sa, input bit sb, input bit lk, input bit en);
    logic [11:0] rx;
    logic [11:0] exp;
    string       tag;
    logic [9:0]  cap;
    exp = nextExp;
    tag = nextTag;
    rx  = '0;
    for (int p = 0; p < 12; p++) begin
      rx[p] = serData;
      if (p == 0) begin
        wordClk = 1'b1; dataIn = a; edgeSel = es;
        syncReqA = sa; syncReqB = sb; pllLock = lk; outEn = en;
      end
      if (p == 6) begin
        wordClk = 1'b0; dataIn = b;
      end
      if (p == 3) check(serDrive == (lk & en), "R8 drive gate", serDrive, lk & en);
      @(negedge clk);
    end
    check(rx == exp, tag, rx, exp);
    // bench model of the requirements
    if (sa || sb) syncCnt = (syncCnt < 5) ? syncCnt + 1 : 5;
    else          syncCnt = 0;
    cap = es ? a : b;
    if (syncCnt == 5) begin
      nextExp = 12'b000000111111;
      nextTag = (sa && sb) ? "R4 training frame" : "R6 single request training";
    end else begin
      nextExp = {1'b0, cap, 1'b1};
      if (prevSync)         nextTag = "R7 return to data";
      else if (syncCnt > 0) nextTag = "R5 short request keeps data";
      else if (es)          nextTag = "R1 R2 R3 rising capture";
      else                  nextTag = "R1 R2 R3 falling capture";
    end
    prevSync = (syncCnt == 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(serData == 1'b0, "R9 reset serData", serData, 0);
    check(serDrive == 1'b0, "R8 no lock in reset", serDrive, 0);
    rstN = 1'b1;
    doWord(10'h155, 10'h0AA, 1, 0, 0, 1, 1);
    for (int i = 0; i < 10; i++)
      doWord(10'(1 << i), 10'(~(1 << i)), i[0], 0, 0, 1, 1);
    for (int i = 0; i < 16; i++)
      doWord(10'((i * 73 + 5) & 10'h3FF), 10'((i * 151 + 9) & 10'h3FF),
             i[0], 0, 0, i[1], i[2]);
    doWord(10'h3FF, 10'h000, 1, 0, 0, 1, 1);
    doWord(10'h3FF, 10'h000, 0, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) doWord(10'(i * 29 + 3), 10'h2AA, 1, 1, 0, 1, 1);
    for (int i = 0; i < 2; i++) doWord(10'(i * 41 + 7), 10'h155, 0, 0, 0, 1, 1);
    for (int i = 0; i < 8; i++) doWord(10'(i * 97 + 1), 10'h1C3, i[0], 0, 1, 0, 1);
    for (int i = 0; i < 3; i++) doWord(10'(i * 53 + 11), 10'h0F0, 1, 0, 0, 1, 1);
    for (int i = 0; i < 7; i++) doWord(10'(i * 61 + 2), 10'h3C3, 1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) doWord(10'(i * 17 + 5), 10'h21B, 0, 0, 0, 1, 1);
    doWord(10'h000, 10'h000, 1, 0, 0, 1, 1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule